// File: doc/BRIEF.md
# Multi-File Physical Register Occupancy Tracker

This block keeps a running count of physical registers in use across several rename register files at the same time. File 0 is a global file that sees every allocation. The other files each own a subset of the logical destination registers. Every charge made to an owning file is also made to file 0.

A small configuration table gives each logical destination register an owning file and a cost. The cost is the number of physical registers one definition consumes, and it may be more than one. The rename stage presents allocate and free requests, each carrying a file index and a cost. A request flagged as a zero idiom or an eliminated move changes no count. Allocate and free may arrive in the same cycle, and their net effect lands in a single update.

Before renaming a group of up to four destination registers, the rename stage asks which files lack room for that group. The answer is a bitmask with one bit per file. A file whose capacity is zero is unbounded. A group that asks for more than a file's whole capacity is clamped to that capacity, so it can still be accepted once the file is empty.

Top module: `prf_occupancy_tracker`

## Requirements
- R1: A synchronous active-high reset sets every used count to zero at the next rising edge, and sets every table entry to owner file 0 with cost 1.
- R2: An allocation that is not flagged skip and has owner file k (k nonzero) adds its cost to the count of file k and to the count of file 0 at the next edge.
- R3: An allocation with owner file 0 adds its cost to file 0 only.
- R4: A free that is not flagged skip subtracts its cost from its owner file (if nonzero) and from file 0 at the next edge.
- R5: An allocation or free with the skip flag set (zero idiom or eliminated move) leaves every count unchanged.
- R6: When an allocation and a free occur in the same cycle, each file's count moves by the net amount in one edge.
- R7: A write to the table sets a logical register's owner file and cost. The new entry is used by queries from the following cycle onward.
- R8: Bit f of the shortage mask is 1 when used(f) + demand(f) > capacity(f). demand(f) is the sum of table costs over the valid query slots owned by f. For f = 0, demand is the sum over all valid slots. The mask is combinational on the current counts.
- R9: A file configured with capacity 0 is unbounded, and its mask bit is never set.
- R10: A demand above a file's capacity is reduced to that capacity before the comparison, so an empty file is not flagged.
- R11: A file with zero demand is never flagged; with no valid query slot the mask is all zero.
- R12: A count never underflows. The result of a combined update stays within the counter width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| cfg_we | input | 1 | table write enable |
| cfg_reg | input | LREG_W | logical register being configured |
| cfg_file | input | FIDX_W | owner file written to the table |
| cfg_cost | input | COST_W | cost written to the table |
| alloc_valid | input | 1 | allocation request |
| alloc_skip | input | 1 | allocation is a zero idiom or eliminated move |
| alloc_file | input | FIDX_W | owner file of the allocation |
| alloc_cost | input | COST_W | registers allocated |
| free_valid | input | 1 | free request |
| free_skip | input | 1 | freed write had allocated nothing |
| free_file | input | FIDX_W | owner file of the free |
| free_cost | input | COST_W | registers released |
| qry_valid | input | NSLOTS | valid bit per query slot |
| qry_reg | input | NSLOTS*LREG_W | logical register per query slot, slot s at bits s*LREG_W |
| qry_short | output | NFILES | bit f set when file f lacks room |
| used_cnt | output | NFILES*CNT_W | used count of file f at bits f*CNT_W |

## Verification
The bench uses the default parameters: four files with capacities 32, 8, 0 and 4, six-bit counters, three-bit costs, sixteen logical registers and four query slots. The capacity-4 file lets a pair of cost-3 destinations exceed the capacity, which exercises clamping. The same file also reaches the exact-fit boundary and is flagged one register past it. The capacity-0 file shows that an unbounded file is never flagged, even when its demand is large. The capacity-8 file can be filled exactly with two allocations.

// File: rtl/prf_occ_pkg.sv
package prf_occ_pkg;
    // Slot-to-file charge rule: file 0 is charged by every slot.
    function automatic logic charges(input int unsigned file_idx, input int unsigned owner);
        return (file_idx == 0) || (owner == file_idx);
    endfunction

    // Width needed for a sum of NSLOTS costs.
    function automatic int unsigned demand_width(input int unsigned cost_w, input int unsigned nslots);
        return cost_w + $clog2(nslots + 1);
    endfunction
endpackage

// File: rtl/prf_cost_table.sv
module prf_cost_table #(
    parameter int NREGS  = 16,
    parameter int NSLOTS = 4,
    parameter int FW     = 2,
    parameter int COST_W = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [$clog2(NREGS)-1:0] wr_reg,
    input  logic [FW-1:0]            wr_file,
    input  logic [COST_W-1:0]        wr_cost,
    input  logic [NSLOTS*$clog2(NREGS)-1:0] rd_reg,
    output logic [NSLOTS*FW-1:0]     rd_file,
    output logic [NSLOTS*COST_W-1:0] rd_cost
);
    localparam int LW = $clog2(NREGS);

    logic [FW-1:0]     file_q [NREGS];
    logic [COST_W-1:0] cost_q [NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) begin
                file_q[i] <= '0;
                cost_q[i] <= COST_W'(1);
            end
        end else if (wr_en) begin
            file_q[wr_reg] <= wr_file;
            cost_q[wr_reg] <= wr_cost;
        end
    end

    for (genvar s = 0; s < NSLOTS; s++) begin : g_rd
        assign rd_file[s*FW +: FW]         = file_q[rd_reg[s*LW +: LW]];
        assign rd_cost[s*COST_W +: COST_W] = cost_q[rd_reg[s*LW +: LW]];
    end
endmodule

// File: rtl/prf_occ_counter.sv
module prf_occ_counter #(
    parameter int CW = 6,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          add_en,
    input  logic [AW-1:0] add_amt,
    input  logic          sub_en,
    input  logic [AW-1:0] sub_amt,
    output logic [CW-1:0] used_o
);
    logic [CW-1:0] used_q;
    logic [CW:0]   grown;
    logic [CW:0]   shrunk;

    always_comb begin
        grown  = {1'b0, used_q} + (add_en ? (CW+1)'(add_amt) : '0);
        shrunk = grown - (sub_en ? (CW+1)'(sub_amt) : '0);
    end

    always_ff @(posedge clk) begin
        if (rst) used_q <= '0;
        else     used_q <= shrunk[CW-1:0];
    end

    assign used_o = used_q;

    // R12
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        sub_en |-> (grown >= (CW+1)'(sub_amt)));
    // R12
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        add_en |-> !grown[CW]);
    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!add_en && !sub_en) |=> $stable(used_o));
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (used_o == '0));
endmodule

// File: rtl/prf_avail_query.sv
module prf_avail_query
    import prf_occ_pkg::*;
#(
    parameter int NFILES = 4,
    parameter int NSLOTS = 4,
    parameter int FW     = 2,
    parameter int COST_W = 3,
    parameter int CW     = 6,
    parameter logic [NFILES*CW-1:0] CAPS = '0
) (
    input  logic [NSLOTS-1:0]        slot_valid,
    input  logic [NSLOTS*FW-1:0]     slot_file,
    input  logic [NSLOTS*COST_W-1:0] slot_cost,
    input  logic [NFILES*CW-1:0]     used,
    output logic [NFILES-1:0]        short_o
);
    localparam int DW = demand_width(COST_W, NSLOTS);
    localparam int SW = ((CW > DW) ? CW : DW) + 1;

    for (genvar f = 0; f < NFILES; f++) begin : g_file
        localparam logic [CW-1:0] CAP = CAPS[f*CW +: CW];
        logic [SW-1:0] demand;
        logic [SW-1:0] clamped;

        always_comb begin
            demand = '0;
            for (int s = 0; s < NSLOTS; s++) begin
                if (slot_valid[s] && charges(f, 32'(slot_file[s*FW +: FW])))
                    demand = demand + SW'(slot_cost[s*COST_W +: COST_W]);
            end
            clamped = demand;
            if (CAP != '0 && demand > SW'(CAP))
                clamped = SW'(CAP);
        end

        if (CAP == '0) begin : g_unbounded
            assign short_o[f] = 1'b0;
        end else begin : g_bounded
            assign short_o[f] = (clamped != '0) &&
                                ((SW'(used[f*CW +: CW]) + clamped) > SW'(CAP));
        end
    end
endmodule

// File: rtl/prf_occupancy_tracker.sv
module prf_occupancy_tracker #(
    parameter int NFILES = 4,
    parameter int NREGS  = 16,
    parameter int NSLOTS = 4,
    parameter int COST_W = 3,
    parameter int CNT_W  = 6,
    parameter logic [NFILES*CNT_W-1:0] CAPS = {6'd4, 6'd0, 6'd8, 6'd32}
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               cfg_we,
    input  logic [$clog2(NREGS)-1:0]           cfg_reg,
    input  logic [$clog2(NFILES)-1:0]          cfg_file,
    input  logic [COST_W-1:0]                  cfg_cost,
    input  logic                               alloc_valid,
    input  logic                               alloc_skip,
    input  logic [$clog2(NFILES)-1:0]          alloc_file,
    input  logic [COST_W-1:0]                  alloc_cost,
    input  logic                               free_valid,
    input  logic                               free_skip,
    input  logic [$clog2(NFILES)-1:0]          free_file,
    input  logic [COST_W-1:0]                  free_cost,
    input  logic [NSLOTS-1:0]                  qry_valid,
    input  logic [NSLOTS*$clog2(NREGS)-1:0]    qry_reg,
    output logic [NFILES-1:0]                  qry_short,
    output logic [NFILES*CNT_W-1:0]            used_cnt
);
    localparam int FW = $clog2(NFILES);

    logic [NSLOTS*FW-1:0]     slot_file;
    logic [NSLOTS*COST_W-1:0] slot_cost;
    logic alloc_live;
    logic free_live;

    assign alloc_live = alloc_valid && !alloc_skip;
    assign free_live  = free_valid && !free_skip;

    prf_cost_table #(
        .NREGS(NREGS), .NSLOTS(NSLOTS), .FW(FW), .COST_W(COST_W)
    ) u_table (
        .clk(clk), .rst(rst),
        .wr_en(cfg_we), .wr_reg(cfg_reg), .wr_file(cfg_file), .wr_cost(cfg_cost),
        .rd_reg(qry_reg), .rd_file(slot_file), .rd_cost(slot_cost)
    );

    for (genvar f = 0; f < NFILES; f++) begin : g_cnt
        logic add_hit;
        logic sub_hit;
        assign add_hit = alloc_live && ((f == 0) || (alloc_file == FW'(f)));
        assign sub_hit = free_live  && ((f == 0) || (free_file  == FW'(f)));

        prf_occ_counter #(.CW(CNT_W), .AW(COST_W)) u_cnt (
            .clk(clk), .rst(rst),
            .add_en(add_hit), .add_amt(alloc_cost),
            .sub_en(sub_hit), .sub_amt(free_cost),
            .used_o(used_cnt[f*CNT_W +: CNT_W])
        );
    end

    prf_avail_query #(
        .NFILES(NFILES), .NSLOTS(NSLOTS), .FW(FW), .COST_W(COST_W),
        .CW(CNT_W), .CAPS(CAPS)
    ) u_query (
        .slot_valid(qry_valid), .slot_file(slot_file), .slot_cost(slot_cost),
        .used(used_cnt), .short_o(qry_short)
    );

    // R2
    global_charge_chk: assert property (@(posedge clk) disable iff (rst)
        (alloc_live && !free_valid) |=>
        (used_cnt[CNT_W-1:0] == $past(used_cnt[CNT_W-1:0]) + CNT_W'($past(alloc_cost))));
    // R11
    idle_query_chk: assert property (@(posedge clk) disable iff (rst)
        (qry_valid == '0) |-> (qry_short == '0));
endmodule

// File: tb/tb_prf_occupancy_tracker.sv
module tb_prf_occupancy_tracker;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst = 1'b1;
    logic cfg_we = 0;       logic [3:0] cfg_reg = 0;   logic [1:0] cfg_file = 0; logic [2:0] cfg_cost = 0;
    logic alloc_valid = 0;  logic alloc_skip = 0;      logic [1:0] alloc_file = 0; logic [2:0] alloc_cost = 0;
    logic free_valid = 0;   logic free_skip = 0;       logic [1:0] free_file = 0;  logic [2:0] free_cost = 0;
    logic [3:0] qry_valid = 0;
    logic [15:0] qry_reg = 0;
    logic [3:0] qry_short;
    logic [23:0] used_cnt;

    prf_occupancy_tracker dut (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_reg(cfg_reg), .cfg_file(cfg_file), .cfg_cost(cfg_cost),
        .alloc_valid(alloc_valid), .alloc_skip(alloc_skip), .alloc_file(alloc_file), .alloc_cost(alloc_cost),
        .free_valid(free_valid), .free_skip(free_skip), .free_file(free_file), .free_cost(free_cost),
        .qry_valid(qry_valid), .qry_reg(qry_reg), .qry_short(qry_short), .used_cnt(used_cnt)
    );

    // staged stimulus for the next cycle
    int s_rst, s_we, s_cr, s_cf, s_cc;
    int s_av, s_as, s_af, s_ac, s_fv, s_fs, s_ff, s_fc;
    int s_qv [4];
    int s_qr [4];

    // reference model
    int caps [4] = '{32, 8, 0, 4};
    int m_used [4];
    int m_tf [16];
    int m_tc [16];

    typedef struct {
        string      tag;
        bit         chk_mask;
        logic [3:0] mask;
        logic [23:0] used;
    } item_t;
    item_t sb [$];

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    task automatic clear_stage();
        s_rst = 0; s_we = 0; s_cr = 0; s_cf = 0; s_cc = 0;
        s_av = 0; s_as = 0; s_af = 0; s_ac = 0;
        s_fv = 0; s_fs = 0; s_ff = 0; s_fc = 0;
        for (int s = 0; s < 4; s++) begin s_qv[s] = 0; s_qr[s] = 0; end
    endtask

    // Driver: one call is one clock cycle.
    task automatic step(input string tag);
        item_t it;
        @(negedge clk);
        rst = (s_rst != 0);
        cfg_we = (s_we != 0); cfg_reg = 4'(s_cr); cfg_file = 2'(s_cf); cfg_cost = 3'(s_cc);
        alloc_valid = (s_av != 0); alloc_skip = (s_as != 0); alloc_file = 2'(s_af); alloc_cost = 3'(s_ac);
        free_valid = (s_fv != 0); free_skip = (s_fs != 0); free_file = 2'(s_ff); free_cost = 3'(s_fc);
        for (int s = 0; s < 4; s++) begin
            qry_valid[s] = (s_qv[s] != 0);
            qry_reg[s*4 +: 4] = 4'(s_qr[s]);
        end
        it.tag = tag;
        it.chk_mask = (s_rst == 0);
        for (int f = 0; f < 4; f++) begin
            int d;
            d = 0;
            for (int s = 0; s < 4; s++)
                if (s_qv[s] != 0 && (f == 0 || m_tf[s_qr[s]] == f)) d += m_tc[s_qr[s]];
            if (caps[f] != 0 && d > caps[f]) d = caps[f];
            it.mask[f] = (caps[f] != 0) && (d != 0) && (m_used[f] + d > caps[f]);
        end
        if (s_rst != 0) begin
            for (int f = 0; f < 4; f++) m_used[f] = 0;
            for (int r = 0; r < 16; r++) begin m_tf[r] = 0; m_tc[r] = 1; end
        end else begin
            if (s_av != 0 && s_as == 0) begin
                m_used[0] += s_ac;
                if (s_af != 0) m_used[s_af] += s_ac;
            end
            if (s_fv != 0 && s_fs == 0) begin
                m_used[0] -= s_fc;
                if (s_ff != 0) m_used[s_ff] -= s_fc;
            end
            if (s_we != 0) begin m_tf[s_cr] = s_cf; m_tc[s_cr] = s_cc; end
        end
        for (int f = 0; f < 4; f++) it.used[f*6 +: 6] = 6'(m_used[f]);
        sb.push_back(it);
        clear_stage();
    endtask

    // Monitor: mask just before the edge, counts just after it.
    initial begin
        forever begin
            item_t it;
            @(negedge clk);
            #3;
            if (sb.size() != 0) begin
                it = sb.pop_front();
                if (it.chk_mask) begin
                    checks++;
                    if (qry_short !== it.mask) begin
                        fails++;
                        $display("FAIL %s mask actual=%b expected=%b", it.tag, qry_short, it.mask);
                    end
                end
                @(posedge clk);
                #1;
                checks++;
                if (used_cnt !== it.used) begin
                    fails++;
                    $display("FAIL %s counts actual=%h expected=%h", it.tag, used_cnt, it.used);
                end
            end
        end
    end

    task automatic cfg(input int r, input int f, input int c);
        s_we = 1; s_cr = r; s_cf = f; s_cc = c;
        step("R7 table write");
    endtask

    initial begin
        clear_stage();
        for (int f = 0; f < 4; f++) m_used[f] = 0;
        s_rst = 1; step("R1 reset");
        s_rst = 1; step("R1 reset");
        // R7 table setup: reg1 f1 c2, reg2 f3 c1, reg3 f2 c3, reg4 f3 c3, reg5 default
        cfg(1, 1, 2); cfg(2, 3, 1); cfg(3, 2, 3); cfg(4, 3, 3);
        s_qv[0] = 1; s_qr[0] = 5; step("R7 default entry query");
        s_av = 1; s_af = 1; s_ac = 2; step("R2 alloc file1");
        s_av = 1; s_af = 0; s_ac = 1; step("R3 alloc file0 only");
        s_av = 1; s_as = 1; s_af = 3; s_ac = 1; step("R5 skipped alloc");
        s_fv = 1; s_fs = 1; s_ff = 1; s_fc = 2; step("R5 skipped free");
        step("R5 idle hold");
        s_av = 1; s_af = 3; s_ac = 3; s_fv = 1; s_ff = 1; s_fc = 2; step("R6 same-cycle alloc and free");
        s_fv = 1; s_ff = 3; s_fc = 3; step("R4 free file3");
        s_qv[0] = 1; s_qr[0] = 4; s_qv[1] = 1; s_qr[1] = 4; step("R10 clamp on empty file");
        s_av = 1; s_af = 3; s_ac = 1; step("R2 alloc file3");
        s_qv[0] = 1; s_qr[0] = 4; step("R8 exact fit not flagged");
        s_qv[0] = 1; s_qr[0] = 4; s_qv[1] = 1; s_qr[1] = 2; step("R8 one past capacity flagged");
        s_qv[0] = 1; s_qr[0] = 4; s_qv[1] = 1; s_qr[1] = 4; step("R10 clamp with occupancy flagged");
        for (int s = 0; s < 4; s++) begin s_qv[s] = 1; s_qr[s] = 3; end
        s_av = 1; s_af = 2; s_ac = 7; step("R9 unbounded file never flagged");
        step("R11 no valid slot");
        s_qv[2] = 1; s_qr[2] = 2; step("R11 zero demand for files 1 and 2");
        s_av = 1; s_af = 1; s_ac = 7; step("R2 fill file1");
        s_av = 1; s_af = 1; s_ac = 1; step("R2 fill file1 exactly");
        s_qv[3] = 1; s_qr[3] = 1; step("R8 full file flagged");
        cfg(1, 2, 1);
        s_qv[3] = 1; s_qr[3] = 1; step("R7 remapped entry used");
        s_fv = 1; s_ff = 1; s_fc = 7; step("R4 free file1");
        s_fv = 1; s_ff = 1; s_fc = 1; step("R12 free to exactly zero");
        s_rst = 1; step("R1 reset after use");
        s_qv[0] = 1; s_qr[0] = 4; step("R1 table back to default");
        step("idle");
        repeat (3) @(posedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule